// File: doc/BRIEF.md
# RTC Alarm Match and Event Interrupt Unit

This block sits beside the time and calendar counters of a real-time clock. It holds two alarm words, compares them against the running BCD time and calendar, and keeps five sticky event flags. Each flag can be routed to a single interrupt line through a mask. The counters report their own events as one-cycle pulses. The alarm event is produced inside the block, on the counter tick where the enabled alarm fields first all equal the current values.

Software reaches the block through a simple write port that selects one of five targets: the time alarm word, the calendar alarm word, a write-one-to-clear command for the flags, a set-enable command and a clear-enable command. The flags, the mask, both alarm words and a four-bit non-valid report are presented as read-back outputs. The non-valid report flags malformed BCD values in the current time, the current calendar and the enabled fields of each alarm word.

Top module: `rtc_evt_alarm_unit`

## Requirements
- R1: After reset, status_o, mask_o, irq_o, talm_o and calm_o are all zero.
- R2: Each alarm field is compared only when its enable bit is set. The fields are: time-alarm seconds [6:0] with enable bit 7, minutes [14:8] with enable bit 15, hours [21:16] with enable bit 23, calendar-alarm month [20:16] with enable bit 23, and date [29:24] with enable bit 31. Status bit 1 (alarm) sets on a tick_i cycle in which every enabled field equals the current value. With no field enabled, it never sets.
- R3: The alarm flag sets only on a tick where the match is true and the match on the previous tick was false. A match that persists across ticks, or a match without a tick, does not set it again.
- R4: A write with wr_sel_i=2 clears exactly those status bits whose wr_data_i bit is one.
- R5: A write with wr_sel_i=3 sets the mask bits that are one in wr_data_i[4:0]. A write with wr_sel_i=4 clears them. mask_o shows the result in the next cycle.
- R6: irq_o is high exactly while some status bit and its mask bit are both one.
- R7: The status bit order is: update acknowledge 0, alarm 1, second 2, time 3, calendar 4. upd_ack_i, sec_ev_i, time_ev_i and cal_ev_i each set their bit, and the bit stays set until it is cleared.
- R8: When a set event and a clear command hit the same bit in the same cycle, the bit ends up set.
- R9: nvalid_o reports non-valid values one cycle after its inputs change. Bit 0 covers the current time, bit 1 the current calendar, bit 2 the enabled time-alarm fields and bit 3 the enabled calendar-alarm fields. A value is non-valid when a BCD units digit exceeds 9 or a field leaves its range: seconds and minutes 00-59, hours 00-23, month 01-12, weekday 1-7, date 01-31, year 00-99, century 00-79.
- R10: wr_sel_i=0 loads the time alarm word and wr_sel_i=1 loads the calendar alarm word. Writes with wr_sel_i of 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse when the counters advance |
| cur_time_i | input | 32 | Current BCD time word |
| cur_cal_i | input | 32 | Current BCD calendar word |
| upd_ack_i | input | 1 | Update-acknowledge event pulse |
| sec_ev_i | input | 1 | Second event pulse |
| time_ev_i | input | 1 | Time event pulse |
| cal_ev_i | input | 1 | Calendar event pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Write target select |
| wr_data_i | input | 32 | Write data |
| status_o | output | 5 | Sticky event flags |
| mask_o | output | 5 | Interrupt mask read-back |
| nvalid_o | output | 4 | Non-valid entry report |
| talm_o | output | 32 | Time alarm word read-back |
| calm_o | output | 32 | Calendar alarm word read-back |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle: flags only fall after a clear command, the second event beats a clear in the same cycle, set-enable and clear-enable writes land in the mask, no alarm flag rises without a tick, the interrupt stays low with an empty mask, and the unused write selects leave state alone. The directed scenarios are the only way to show alarm matching with partial field enables, the single firing on a persistent match, the re-arming after a mismatch, and the non-valid range rules for each field.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
    localparam int DW      = 32;
    localparam int NUM_EV  = 5;
    localparam int NUM_NV  = 4;
    localparam int SEL_W   = 3;

    // status / mask bit positions
    localparam int EV_ACK  = 0;
    localparam int EV_ALM  = 1;
    localparam int EV_SEC  = 2;
    localparam int EV_TIM  = 3;
    localparam int EV_CAL  = 4;

    // alarm field enable bit positions
    localparam int TA_SEC_EN  = 7;
    localparam int TA_MIN_EN  = 15;
    localparam int TA_HR_EN   = 23;
    localparam int CA_MON_EN  = 23;
    localparam int CA_DATE_EN = 31;

    typedef enum logic [SEL_W-1:0] {
        SEL_TALM = 3'd0,
        SEL_CALM = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_IEN  = 3'd3,
        SEL_IDIS = 3'd4
    } wsel_e;

    typedef struct packed {
        logic [DW-1:0]     talm;
        logic [DW-1:0]     calm;
        logic [NUM_EV-1:0] status;
        logic [NUM_EV-1:0] mask;
        logic              prev_match;
        logic [NUM_NV-1:0] nval;
    } evt_state_t;
endpackage

// File: rtl/rtc_bcd_range.sv
module rtc_bcd_range #(
    parameter int            W  = 7,
    parameter logic [W-1:0]  LO = '0,
    parameter logic [W-1:0]  HI = '1
) (
    input  logic [W-1:0] val_i,
    output logic         ok_o
);
    logic digit_ok;

    generate
        if (W >= 4) begin : g_nib
            assign digit_ok = (val_i[3:0] <= 4'd9);
        end else begin : g_bin
            assign digit_ok = 1'b1;
        end
    endgenerate

    assign ok_o = digit_ok && (val_i >= LO) && (val_i <= HI);
endmodule

// File: rtl/rtc_time_ok.sv
module rtc_time_ok
    import rtc_evt_pkg::*;
(
    input  logic [DW-1:0] word_i,
    output logic [2:0]    ok_o      // 0 sec, 1 min, 2 hour
);
    rtc_bcd_range #(.W(7), .LO(7'h00), .HI(7'h59)) u_sec (.val_i(word_i[6:0]),   .ok_o(ok_o[0]));
    rtc_bcd_range #(.W(7), .LO(7'h00), .HI(7'h59)) u_min (.val_i(word_i[14:8]),  .ok_o(ok_o[1]));
    rtc_bcd_range #(.W(6), .LO(6'h00), .HI(6'h23)) u_hr  (.val_i(word_i[21:16]), .ok_o(ok_o[2]));

    logic unused_bits;
    assign unused_bits = ^{word_i[DW-1:22], word_i[15], word_i[7]};
endmodule

// File: rtl/rtc_cal_ok.sv
module rtc_cal_ok
    import rtc_evt_pkg::*;
(
    input  logic [DW-1:0] word_i,
    output logic [4:0]    ok_o      // 0 cent, 1 year, 2 month, 3 weekday, 4 date
);
    rtc_bcd_range #(.W(7), .LO(7'h00), .HI(7'h79)) u_cent (.val_i(word_i[6:0]),   .ok_o(ok_o[0]));
    rtc_bcd_range #(.W(8), .LO(8'h00), .HI(8'h99)) u_year (.val_i(word_i[15:8]),  .ok_o(ok_o[1]));
    rtc_bcd_range #(.W(5), .LO(5'h01), .HI(5'h12)) u_mon  (.val_i(word_i[20:16]), .ok_o(ok_o[2]));
    rtc_bcd_range #(.W(3), .LO(3'd1),  .HI(3'd7))  u_wday (.val_i(word_i[23:21]), .ok_o(ok_o[3]));
    rtc_bcd_range #(.W(6), .LO(6'h01), .HI(6'h31)) u_date (.val_i(word_i[29:24]), .ok_o(ok_o[4]));

    logic unused_bits;
    assign unused_bits = ^{word_i[DW-1:30], word_i[7]};
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_evt_pkg::*;
(
    input  logic [DW-1:0] time_i,
    input  logic [DW-1:0] cal_i,
    input  logic [DW-1:0] talm_i,
    input  logic [DW-1:0] calm_i,
    output logic          match_o
);
    logic [4:0] en;
    logic [4:0] eq;

    assign en = {calm_i[CA_DATE_EN], calm_i[CA_MON_EN],
                 talm_i[TA_HR_EN], talm_i[TA_MIN_EN], talm_i[TA_SEC_EN]};
    assign eq = {cal_i[29:24]  == calm_i[29:24],
                 cal_i[20:16]  == calm_i[20:16],
                 time_i[21:16] == talm_i[21:16],
                 time_i[14:8]  == talm_i[14:8],
                 time_i[6:0]   == talm_i[6:0]};

    // at least one enabled field, and every enabled field equal
    assign match_o = (|en) && (&(eq | ~en));

    logic unused_bits;
    assign unused_bits = ^{time_i[DW-1:22], time_i[15], time_i[7],
                           cal_i[DW-1:30], cal_i[23:21], cal_i[15:0],
                           talm_i[DW-1:24], talm_i[22],
                           calm_i[30], calm_i[22:21], calm_i[15:0]};
endmodule

// File: rtl/rtc_evt_alarm_unit.sv
module rtc_evt_alarm_unit
    import rtc_evt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [DW-1:0]     cur_time_i,
    input  logic [DW-1:0]     cur_cal_i,
    input  logic              upd_ack_i,
    input  logic              sec_ev_i,
    input  logic              time_ev_i,
    input  logic              cal_ev_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [NUM_EV-1:0] status_o,
    output logic [NUM_EV-1:0] mask_o,
    output logic [NUM_NV-1:0] nvalid_o,
    output logic [DW-1:0]     talm_o,
    output logic [DW-1:0]     calm_o,
    output logic              irq_o
);
    evt_state_t st_d, st_q;

    logic [2:0] t_ok, ta_ok;
    logic [4:0] c_ok, ca_ok;
    logic       match;
    logic [NUM_NV-1:0] nv_now;

    rtc_time_ok   u_tchk  (.word_i(cur_time_i), .ok_o(t_ok));
    rtc_cal_ok    u_cchk  (.word_i(cur_cal_i),  .ok_o(c_ok));
    rtc_time_ok   u_tachk (.word_i(st_q.talm),  .ok_o(ta_ok));
    rtc_cal_ok    u_cachk (.word_i(st_q.calm),  .ok_o(ca_ok));

    rtc_alarm_cmp u_cmp (
        .time_i  (cur_time_i),
        .cal_i   (cur_cal_i),
        .talm_i  (st_q.talm),
        .calm_i  (st_q.calm),
        .match_o (match)
    );

    // only enabled alarm fields take part in the alarm validity report
    assign nv_now[0] = ~&t_ok;
    assign nv_now[1] = ~&c_ok;
    assign nv_now[2] = |({st_q.talm[TA_HR_EN], st_q.talm[TA_MIN_EN], st_q.talm[TA_SEC_EN]} & ~ta_ok);
    assign nv_now[3] = |({st_q.calm[CA_DATE_EN], st_q.calm[CA_MON_EN]} & ~{ca_ok[4], ca_ok[2]});

    logic unused_ok;
    assign unused_ok = ^{ca_ok[3], ca_ok[1], ca_ok[0]};

    always_comb begin
        logic [NUM_EV-1:0] set_v;
        logic [NUM_EV-1:0] clr_v;
        st_d  = st_q;
        set_v = '0;
        clr_v = '0;

        set_v[EV_ACK] = upd_ack_i;
        set_v[EV_ALM] = tick_i && match && !st_q.prev_match;
        set_v[EV_SEC] = sec_ev_i;
        set_v[EV_TIM] = time_ev_i;
        set_v[EV_CAL] = cal_ev_i;

        if (wr_en_i) begin
            case (wsel_e'(wr_sel_i))
                SEL_TALM: st_d.talm = wr_data_i;
                SEL_CALM: st_d.calm = wr_data_i;
                SEL_CLR:  clr_v     = wr_data_i[NUM_EV-1:0];
                SEL_IEN:  st_d.mask = st_q.mask | wr_data_i[NUM_EV-1:0];
                SEL_IDIS: st_d.mask = st_q.mask & ~wr_data_i[NUM_EV-1:0];
                default:  ;
            endcase
        end

        // a set in the same cycle as a clear wins
        st_d.status = (st_q.status & ~clr_v) | set_v;

        if (tick_i) begin
            st_d.prev_match = match;
        end

        st_d.nval = nv_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign nvalid_o = st_q.nval;
    assign talm_o   = st_q.talm;
    assign calm_o   = st_q.calm;
    assign irq_o    = |(st_q.status & st_q.mask);

    logic unused_data;
    assign unused_data = ^wr_data_i[DW-1:NUM_EV];
endmodule

// File: rtl/rtc_evt_alarm_chk.sv
module rtc_evt_alarm_chk
    import rtc_evt_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              sec_ev_i,
    input logic              wr_en_i,
    input logic [SEL_W-1:0]  wr_sel_i,
    input logic [DW-1:0]     wr_data_i,
    input logic [NUM_EV-1:0] status_o,
    input logic [NUM_EV-1:0] mask_o,
    input logic [DW-1:0]     talm_o,
    input logic [DW-1:0]     calm_o,
    input logic              irq_o
);
    // R7: flags only drop after a clear command
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_sel_i == SEL_CLR) |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R8: second event beats a simultaneous clear
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_ev_i |=> status_o[EV_SEC]);

    // R5: set-enable lands in the mask
    a_r5_ien: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == SEL_IEN) |=>
            ((mask_o & $past(wr_data_i[NUM_EV-1:0])) == $past(wr_data_i[NUM_EV-1:0])));

    // R5: clear-enable removes mask bits
    a_r5_idis: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == SEL_IDIS) |=> ((mask_o & $past(wr_data_i[NUM_EV-1:0])) == '0));

    // R3: the alarm flag never rises without a tick
    a_r3_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> !$rose(status_o[EV_ALM]));

    // R6: empty mask keeps the line low
    a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_o == '0) |-> !irq_o);

    // R10: unused selects change nothing
    a_r10_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i > 3'd4) |=> ($stable(mask_o) && $stable(talm_o) && $stable(calm_o)));
endmodule

bind rtc_evt_alarm_unit rtc_evt_alarm_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .sec_ev_i  (sec_ev_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .status_o  (status_o),
    .mask_o    (mask_o),
    .talm_o    (talm_o),
    .calm_o    (calm_o),
    .irq_o     (irq_o)
);

// File: tb/rtc_evt_alarm_unit_tb_top.sv
module rtc_evt_alarm_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] cur_time = '0;
    logic [31:0] cur_cal = '0;
    logic        upd_ack = 1'b0, sec_ev = 1'b0, time_ev = 1'b0, cal_ev = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  status, mask;
    logic [3:0]  nvalid;
    logic [31:0] talm, calm;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    rtc_evt_alarm_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .cur_time_i(cur_time), .cur_cal_i(cur_cal),
        .upd_ack_i(upd_ack), .sec_ev_i(sec_ev), .time_ev_i(time_ev), .cal_ev_i(cal_ev),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .status_o(status), .mask_o(mask), .nvalid_o(nvalid),
        .talm_o(talm), .calm_o(calm), .irq_o(irq)
    );

    function automatic logic [31:0] mk_time(logic [5:0] h, logic [6:0] m, logic [6:0] s);
        return {10'd0, h, 1'b0, m, 1'b0, s};
    endfunction

    function automatic logic [31:0] mk_cal(logic [6:0] c, logic [7:0] y, logic [4:0] mo,
                                           logic [2:0] wd, logic [5:0] d);
        return {2'd0, d, wd, mo, y, 1'b0, c};
    endfunction

    localparam logic [31:0] BASE_T = 32'h0010_0000;          // 10:00:00
    localparam logic [31:0] BASE_C = 32'h1566_2420;          // date 15, wday 3, month 06, year 24, cent 20

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", {27'd0, status}, 32'h0);
        chk("R1 mask",   {27'd0, mask},   32'h0);
        chk("R1 irq",    {31'd0, irq},    32'h0);
        chk("R1 talm",   talm, 32'h0);
        chk("R1 calm",   calm, 32'h0);
        chk("R9 valid inputs", {28'd0, nvalid}, 32'h0);
    endtask

    task automatic t_events();
        sec_ev = 1'b1; cyc(); sec_ev = 1'b0;
        chk("R7 second event", {27'd0, status}, 32'h04);
        chk("R6 masked off", {31'd0, irq}, 32'h0);
        upd_ack = 1'b1; time_ev = 1'b1; cal_ev = 1'b1; cyc();
        upd_ack = 1'b0; time_ev = 1'b0; cal_ev = 1'b0;
        cyc();
        chk("R7 sticky set", {27'd0, status}, 32'h1D);
        wr(3'd3, 32'h04);
        chk("R5 enable", {27'd0, mask}, 32'h04);
        chk("R6 irq on", {31'd0, irq}, 32'h1);
        wr(3'd4, 32'h04);
        chk("R5 disable", {27'd0, mask}, 32'h00);
        chk("R6 irq off", {31'd0, irq}, 32'h0);
        wr(3'd3, 32'h11);
        chk("R5 enable two", {27'd0, mask}, 32'h11);
    endtask

    task automatic t_clear();
        wr(3'd2, 32'h05);
        chk("R4 partial clear", {27'd0, status}, 32'h18);
        chk("R6 irq via bit4", {31'd0, irq}, 32'h1);
        wr(3'd2, 32'h10);
        chk("R4 clear bit4", {27'd0, status}, 32'h08);
        chk("R6 irq drops", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_priority();
        sec_ev = 1'b1; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'h04;
        cyc();
        sec_ev = 1'b0; wr_en = 1'b0;
        chk("R8 set beats clear", {27'd0, status}, 32'h0C);
        wr(3'd2, 32'h1F);
        chk("R4 clear all", {27'd0, status}, 32'h00);
    endtask

    task automatic t_alarm();
        wr(3'd0, mk_time(6'h10, 7'h30, 7'h00) | (32'h1 << 23));
        chk("R10 talm load", talm, 32'h0090_3000);
        chk("R3 no set without tick", {27'd0, status}, 32'h0);
        do_tick();
        chk("R2 hour-only match", {27'd0, status}, 32'h02);
        wr(3'd3, 32'h02);
        chk("R6 alarm irq", {31'd0, irq}, 32'h1);
        wr(3'd2, 32'h02);
        cur_time = mk_time(6'h10, 7'h01, 7'h00);
        do_tick();
        chk("R3 persistent match", {27'd0, status}, 32'h0);
        cur_time = mk_time(6'h11, 7'h00, 7'h00);
        do_tick();
        chk("R2 mismatch", {27'd0, status}, 32'h0);
        cur_time = BASE_T;
        do_tick();
        chk("R3 rearm fires", {27'd0, status}, 32'h02);
        wr(3'd2, 32'h02);
        wr(3'd1, (32'h07 << 16) | (32'h1 << 23));
        chk("R10 calm load", calm, 32'h0087_0000);
        do_tick();
        chk("R2 month mismatch", {27'd0, status}, 32'h0);
        cur_cal = mk_cal(7'h20, 8'h24, 5'h07, 3'd3, 6'h15);
        do_tick();
        chk("R2 hour and month match", {27'd0, status}, 32'h02);
        wr(3'd2, 32'h02);
        cur_cal = BASE_C;
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        do_tick();
        cur_cal = mk_cal(7'h20, 8'h24, 5'h06, 3'd3, 6'h16);
        do_tick();
        chk("R2 no field enabled", {27'd0, status}, 32'h0);
        cur_cal = BASE_C;
    endtask

    task automatic t_valid();
        cur_time = mk_time(6'h10, 7'h00, 7'h5A); cyc();
        chk("R9 bad seconds digit", {28'd0, nvalid}, 32'h1);
        cur_time = mk_time(6'h24, 7'h00, 7'h00); cyc();
        chk("R9 hour 24", {28'd0, nvalid}, 32'h1);
        cur_time = BASE_T;
        cur_cal = mk_cal(7'h20, 8'h24, 5'h13, 3'd3, 6'h15); cyc();
        chk("R9 month 13", {28'd0, nvalid}, 32'h2);
        cur_cal = mk_cal(7'h20, 8'h24, 5'h06, 3'd3, 6'h00); cyc();
        chk("R9 date 0", {28'd0, nvalid}, 32'h2);
        cur_cal = BASE_C; cyc();
        chk("R9 restored", {28'd0, nvalid}, 32'h0);
        wr(3'd0, mk_time(6'h24, 7'h00, 7'h00) | (32'h1 << 23));
        cyc();
        chk("R9 alarm hour 24", {28'd0, nvalid}, 32'h4);
        wr(3'd0, mk_time(6'h10, 7'h00, 7'h7F));
        cyc();
        chk("R9 disabled field ignored", {28'd0, nvalid}, 32'h0);
        wr(3'd1, 32'h8000_0000);
        cyc();
        chk("R9 alarm date 0", {28'd0, nvalid}, 32'h8);
    endtask

    task automatic t_ignored();
        logic [4:0]  m0, s0;
        logic [31:0] ta0, ca0;
        sec_ev = 1'b1; cyc(); sec_ev = 1'b0;
        m0 = mask; s0 = status; ta0 = talm; ca0 = calm;
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0000_0000);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R10 mask kept", {27'd0, mask}, {27'd0, m0});
        chk("R10 status kept", {27'd0, status}, {27'd0, s0});
        chk("R10 talm kept", talm, ta0);
        chk("R10 calm kept", calm, ca0);
    endtask

    initial begin
        cur_time = BASE_T;
        cur_cal  = BASE_C;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc(); cyc();
        t_reset();
        t_events();
        t_clear();
        t_priority();
        t_alarm();
        t_valid();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule